// File: doc/BRIEF.md
# Thread Block Dispatcher

This block takes one launched grid of thread blocks and spreads them over a set of multiprocessor slots. A launch gives the number of blocks, the threads in each block and the shared-memory bytes each block needs. All blocks of a grid have the same size. The dispatcher hands out block indices in rising order, from zero up to the count minus one. A block always goes whole to one slot, and only to a slot that can hold it: the slot must stay within its resident-block limit, its resident-thread limit and its shared-memory capacity at the same time.

Each slot has a valid/ready assign channel. A shared index bus carries the block index on that channel. Each slot also has a completion input. A pulse on it returns the resources of one block on that slot. When capacity frees up, the dispatcher gives further pending blocks to that slot. Once every block has been handed out and reported complete, the grid-done output pulses and the dispatcher returns to idle.

Top module: `tbd_top`

## Requirements
- R1: Block indices are handed out in rising order 0, 1, … up to the launched count minus one. Each index goes out exactly once. A block is assigned at a clock edge where `asg_valid[s]` and `asg_ready[s]` are both high.
- R2: No slot ever holds more than MAX_BLK (8) resident blocks.
- R3: No slot ever holds more than MAX_THR (768) resident threads. With 256-thread blocks, three fit per slot.
- R4: No slot ever uses more than SMEM_CAP (16384) shared-memory bytes. A request that exactly fills the remainder is admitted.
- R5: At most one slot sees `asg_valid` at a time. The target slot is chosen round-robin among the slots where the block fits, starting from the slot after the last one granted. After reset the search starts at slot 0.
- R6: An offer stays on the same slot, with the same index, until that slot accepts it.
- R7: A `blk_done[s]` pulse returns one block's count, threads and bytes to slot s. A pending block that could not fit before may then be assigned to slot s.
- R8: A launch whose threads per block exceed 768, or whose bytes per block exceed 16384, sets `launch_err` in the next cycle. That launch issues no block and `busy` stays low. The next accepted launch clears `launch_err`.
- R9: `grid_done` is high for exactly one cycle: the cycle after the completion count reaches the launched count with every block assigned. `busy` is low from that same cycle on.
- R10: A `blk_done[s]` pulse for a slot with no resident block changes no counter. It sets `proto_err`, which stays set until reset.
- R11: A `launch_start` pulse while `busy` is high is ignored. The running grid keeps its own block count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_start | input | 1 | One-cycle launch request, accepted while idle |
| launch_blocks | input | IDX_W | Number of blocks in the grid |
| launch_threads | input | THR_W | Threads per block |
| launch_smem | input | SMEM_W | Shared-memory bytes per block |
| busy | output | 1 | A grid is in progress |
| launch_err | output | 1 | Last launch was rejected as too large for one slot |
| grid_done | output | 1 | One-cycle pulse when the whole grid has finished |
| proto_err | output | 1 | Sticky: a completion arrived for an empty slot |
| asg_valid | output | NUM_SM | Per-slot assign offer |
| asg_ready | input | NUM_SM | Per-slot assign acceptance |
| asg_idx | output | IDX_W | Block index of the current offer |
| blk_done | input | NUM_SM | Per-slot completion of one block |

## Verification
The bench fills the slots until each of the three limits binds on its own. It then checks that the assignment count stalls at exactly 32, 12 or 8 blocks, including the case where the shared memory is exactly full. A design that checked only one limit would overfill a slot. A design that used a strict comparison would leave a block that fits unissued.

A single completion is sent to one saturated slot. The next block must land there, with the next index in sequence. A design that never refilled would hang.

Other cases cover:
- a held offer while the ready inputs are low, which must not wander to another slot or change its index;
- rejected launches at 769 threads and 16385 bytes, and an accepted launch at exactly 768 threads and 16384 bytes;
- a stray completion on an idle slot, which must raise only the protocol error;
- the exact cycle of the grid-done pulse, where an off-by-one design would be early, late or stretched.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/tbd_fit.sv
module tbd_fit #(
    parameter int MAX_BLK  = 8,
    parameter int MAX_THR  = 768,
    parameter int SMEM_CAP = 16384,
    parameter int BLK_W    = $clog2(MAX_BLK + 1),
    parameter int THR_W    = $clog2(MAX_THR + 1),
    parameter int SMEM_W   = $clog2(SMEM_CAP + 1)
) (
    input  logic [BLK_W-1:0]  blk_cnt,
    input  logic [THR_W-1:0]  thr_cnt,
    input  logic [SMEM_W-1:0] smem_cnt,
    input  logic [THR_W-1:0]  thr_req,
    input  logic [SMEM_W-1:0] smem_req,
    output logic              fits
);
    localparam logic [BLK_W-1:0]  BLK_LIM  = BLK_W'(MAX_BLK);
    localparam logic [THR_W:0]    THR_LIM  = (THR_W + 1)'(MAX_THR);
    localparam logic [SMEM_W:0]   SMEM_LIM = (SMEM_W + 1)'(SMEM_CAP);

    logic [THR_W:0]  thr_sum;
    logic [SMEM_W:0] smem_sum;

    always_comb begin
        thr_sum  = {1'b0, thr_cnt} + {1'b0, thr_req};
        smem_sum = {1'b0, smem_cnt} + {1'b0, smem_req};
        fits     = (blk_cnt < BLK_LIM) && (thr_sum <= THR_LIM) && (smem_sum <= SMEM_LIM);
    end

endmodule

// File: rtl/tbd_rr_arb.sv
module tbd_rr_arb #(
    parameter int NUM_SM = 4,
    parameter int SM_W   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
    input  logic [NUM_SM-1:0] req,
    input  logic [SM_W-1:0]   last,
    output logic              gnt_vld,
    output logic [SM_W-1:0]   gnt_idx
);
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int i = 1; i <= NUM_SM; i++) begin
            if (!gnt_vld && req[(int'(last) + i) % NUM_SM]) begin
                gnt_vld = 1'b1;
                gnt_idx = SM_W'((int'(last) + i) % NUM_SM);
            end
        end
    end

endmodule

// File: rtl/tbd_top.sv
module tbd_top
    import tbd_pkg::*;
#(
    parameter int NUM_SM   = 4,
    parameter int MAX_BLK  = 8,
    parameter int MAX_THR  = 768,
    parameter int SMEM_CAP = 16384,
    parameter int IDX_W    = 16,
    localparam int BLK_W   = $clog2(MAX_BLK + 1),
    localparam int THR_W   = $clog2(MAX_THR + 1),
    localparam int SMEM_W  = $clog2(SMEM_CAP + 1),
    localparam int SM_W    = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_start,
    input  logic [IDX_W-1:0]  launch_blocks,
    input  logic [THR_W-1:0]  launch_threads,
    input  logic [SMEM_W-1:0] launch_smem,
    output logic              busy,
    output logic              launch_err,
    output logic              grid_done,
    output logic              proto_err,
    output logic [NUM_SM-1:0] asg_valid,
    input  logic [NUM_SM-1:0] asg_ready,
    output logic [IDX_W-1:0]  asg_idx,
    input  logic [NUM_SM-1:0] blk_done
);

    typedef struct packed {
        run_state_e                    st;
        logic [IDX_W-1:0]              total;
        logic [IDX_W-1:0]              next_idx;
        logic [IDX_W-1:0]              fin_cnt;
        logic [THR_W-1:0]              thr_req;
        logic [SMEM_W-1:0]             smem_req;
        logic                          off_vld;
        logic [SM_W-1:0]               off_sm;
        logic [SM_W-1:0]               last_sm;
        logic [NUM_SM-1:0][BLK_W-1:0]  blk;
        logic [NUM_SM-1:0][THR_W-1:0]  thr;
        logic [NUM_SM-1:0][SMEM_W-1:0] smem;
        logic                          lerr;
        logic                          perr;
        logic                          gdone;
    } dsp_state_t;

    dsp_state_t q, d;

    logic [NUM_SM-1:0] fit_v;
    logic [NUM_SM-1:0] inc_v;
    logic [NUM_SM-1:0] dec_v;
    logic              commit;
    logic              pending;
    logic              gnt_vld;
    logic [SM_W-1:0]   gnt_idx;

    // admission check, one per slot
    for (genvar s = 0; s < NUM_SM; s++) begin : g_fit
        tbd_fit #(
            .MAX_BLK (MAX_BLK),
            .MAX_THR (MAX_THR),
            .SMEM_CAP(SMEM_CAP),
            .BLK_W   (BLK_W),
            .THR_W   (THR_W),
            .SMEM_W  (SMEM_W)
        ) u_fit (
            .blk_cnt (q.blk[s]),
            .thr_cnt (q.thr[s]),
            .smem_cnt(q.smem[s]),
            .thr_req (q.thr_req),
            .smem_req(q.smem_req),
            .fits    (fit_v[s])
        );
    end

    tbd_rr_arb #(
        .NUM_SM(NUM_SM),
        .SM_W  (SM_W)
    ) u_arb (
        .req    (fit_v),
        .last   (q.last_sm),
        .gnt_vld(gnt_vld),
        .gnt_idx(gnt_idx)
    );

    always_comb begin
        commit  = q.off_vld && asg_ready[q.off_sm];
        pending = (q.st == ST_RUN) && (q.next_idx != q.total);
        for (int s = 0; s < NUM_SM; s++) begin
            inc_v[s] = commit && (q.off_sm == SM_W'(s));
            dec_v[s] = blk_done[s] && (q.blk[s] != '0);
        end
    end

    always_comb begin
        d       = q;
        d.gdone = 1'b0;

        // per-slot accounting: grants add, completions subtract
        for (int s = 0; s < NUM_SM; s++) begin
            if (blk_done[s] && !dec_v[s]) begin
                d.perr = 1'b1;
            end
            if (inc_v[s] && !dec_v[s]) begin
                d.blk[s]  = q.blk[s] + 1'b1;
                d.thr[s]  = q.thr[s] + q.thr_req;
                d.smem[s] = q.smem[s] + q.smem_req;
            end else if (dec_v[s] && !inc_v[s]) begin
                d.blk[s]  = q.blk[s] - 1'b1;
                d.thr[s]  = q.thr[s] - q.thr_req;
                d.smem[s] = q.smem[s] - q.smem_req;
            end
        end
        d.fin_cnt = q.fin_cnt + IDX_W'($countones(dec_v));

        // offer handling
        if (commit) begin
            d.off_vld  = 1'b0;
            d.next_idx = q.next_idx + 1'b1;
            d.last_sm  = q.off_sm;
        end else if (!q.off_vld && pending && gnt_vld) begin
            d.off_vld = 1'b1;
            d.off_sm  = gnt_idx;
        end

        // grid completion
        if (q.st == ST_RUN && !pending && !q.off_vld && q.fin_cnt == q.total) begin
            d.gdone = 1'b1;
            d.st    = ST_IDLE;
        end

        // launch intake
        if (q.st == ST_IDLE && launch_start) begin
            if (int'(launch_threads) > MAX_THR || int'(launch_smem) > SMEM_CAP) begin
                d.lerr = 1'b1;
            end else begin
                d.lerr     = 1'b0;
                d.st       = ST_RUN;
                d.total    = launch_blocks;
                d.next_idx = '0;
                d.fin_cnt  = '0;
                d.thr_req  = launch_threads;
                d.smem_req = launch_smem;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.last_sm <= SM_W'(NUM_SM - 1);
        end else begin
            q <= d;
        end
    end

    for (genvar s = 0; s < NUM_SM; s++) begin : g_out
        assign asg_valid[s] = q.off_vld && (q.off_sm == SM_W'(s));
    end

    assign asg_idx    = q.next_idx;
    assign busy       = (q.st == ST_RUN);
    assign launch_err = q.lerr;
    assign grid_done  = q.gdone;
    assign proto_err  = q.perr;

endmodule

// File: rtl/tbd_checker.sv
module tbd_checker #(
    parameter int NUM_SM   = 4,
    parameter int MAX_BLK  = 8,
    parameter int MAX_THR  = 768,
    parameter int SMEM_CAP = 16384,
    parameter int IDX_W    = 16,
    parameter int BLK_W    = 4,
    parameter int THR_W    = 10,
    parameter int SMEM_W   = 15
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_SM-1:0]             asg_valid,
    input logic [NUM_SM-1:0]             asg_ready,
    input logic [IDX_W-1:0]              asg_idx,
    input logic [NUM_SM-1:0][BLK_W-1:0]  blk_cnt,
    input logic [NUM_SM-1:0][THR_W-1:0]  thr_cnt,
    input logic [NUM_SM-1:0][SMEM_W-1:0] smem_cnt,
    input logic                          busy,
    input logic                          launch_err,
    input logic                          grid_done,
    input logic                          proto_err
);

    assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|(asg_valid & asg_ready)) |=> (asg_idx == $past(asg_idx) + 1'b1));

    assert_one_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(asg_valid));

    assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        launch_err |-> (asg_valid == '0) && !busy);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grid_done |-> !busy ##1 !grid_done);

    assert_proto_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    for (genvar s = 0; s < NUM_SM; s++) begin : g_slot
        assert_blk_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
            int'(blk_cnt[s]) <= MAX_BLK);

        assert_thr_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            int'(thr_cnt[s]) <= MAX_THR);

        assert_smem_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            int'(smem_cnt[s]) <= SMEM_CAP);

        assert_offer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (asg_valid[s] && !asg_ready[s]) |=> asg_valid[s] && $stable(asg_idx));
    end

endmodule

bind tbd_top tbd_checker #(
    .NUM_SM  (NUM_SM),
    .MAX_BLK (MAX_BLK),
    .MAX_THR (MAX_THR),
    .SMEM_CAP(SMEM_CAP),
    .IDX_W   (IDX_W),
    .BLK_W   (BLK_W),
    .THR_W   (THR_W),
    .SMEM_W  (SMEM_W)
) u_tbd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .asg_valid (asg_valid),
    .asg_ready (asg_ready),
    .asg_idx   (asg_idx),
    .blk_cnt   (q.blk),
    .thr_cnt   (q.thr),
    .smem_cnt  (q.smem),
    .busy      (busy),
    .launch_err(launch_err),
    .grid_done (grid_done),
    .proto_err (proto_err)
);

// File: tb/test_tbd_top.sv
module test_tbd_top;
    localparam int NUM_SM = 4;
    localparam int IDX_W  = 16;
    localparam int THR_W  = 10;
    localparam int SMEM_W = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              launch_start = 1'b0;
    logic [IDX_W-1:0]  launch_blocks = '0;
    logic [THR_W-1:0]  launch_threads = '0;
    logic [SMEM_W-1:0] launch_smem = '0;
    logic              busy, launch_err, grid_done, proto_err;
    logic [NUM_SM-1:0] asg_valid;
    logic [NUM_SM-1:0] asg_ready = '1;
    logic [IDX_W-1:0]  asg_idx;
    logic [NUM_SM-1:0] blk_done = '0;

    always #5 clk = ~clk;

    tbd_top i_tbd_top (
        .clk(clk), .rst_n(rst_n), .launch_start(launch_start),
        .launch_blocks(launch_blocks), .launch_threads(launch_threads),
        .launch_smem(launch_smem), .busy(busy), .launch_err(launch_err),
        .grid_done(grid_done), .proto_err(proto_err), .asg_valid(asg_valid),
        .asg_ready(asg_ready), .asg_idx(asg_idx), .blk_done(blk_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int asg_sm [0:255];
    int asg_ix [0:255];
    int n_asg = 0;
    int res [NUM_SM];
    int pend_sm = -1;
    int last_fin_cyc = 0;
    int done_cyc = 0;
    int done_seen = 0;

    // monitor: logs grants and completions as the design will see them
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int s = 0; s < NUM_SM; s++) res[s] = 0;
            pend_sm = -1;
        end else begin
            for (int s = 0; s < NUM_SM; s++) begin
                if (blk_done[s] && res[s] > 0) begin
                    res[s]--;
                    last_fin_cyc = cyc;
                end
            end
            if (pend_sm >= 0) begin
                res[pend_sm]++;
                pend_sm = -1;
            end
            for (int s = 0; s < NUM_SM; s++) begin
                if (asg_valid[s] && asg_ready[s]) begin
                    if (n_asg < 256) begin
                        asg_sm[n_asg] = s;
                        asg_ix[n_asg] = int'(asg_idx);
                    end
                    n_asg++;
                    pend_sm = s;
                end
            end
            if (grid_done) begin
                done_seen++;
                done_cyc = cyc;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic launch(input int blocks, input int thr, input int smem);
        @(negedge clk);
        #1;
        launch_blocks  = IDX_W'(blocks);
        launch_threads = THR_W'(thr);
        launch_smem    = SMEM_W'(smem);
        launch_start   = 1'b1;
        @(negedge clk);
        #1;
        launch_start = 1'b0;
    endtask

    task automatic complete(input int s);
        @(negedge clk);
        #1;
        blk_done[s] = 1'b1;
        @(negedge clk);
        #1;
        blk_done = '0;
    endtask

    task automatic drain(input string req);
        int start_seen;
        int guard;
        start_seen = done_seen;
        guard = 0;
        while (done_seen == start_seen && guard < 3000) begin
            @(negedge clk);
            #1;
            for (int s = 0; s < NUM_SM; s++) blk_done[s] = (res[s] > 0);
            guard++;
        end
        blk_done = '0;
        check(done_seen == start_seen + 1, req, done_seen - start_seen, 1);
    endtask

    task automatic t_reset();
        check(busy == 1'b0 && grid_done == 1'b0, "R9 reset idle", int'(busy), 0);
        check(asg_valid == '0, "R5 reset no offer", int'(asg_valid), 0);
        check(launch_err == 1'b0 && proto_err == 1'b0, "R10 reset errors", int'(proto_err), 0);
    endtask

    task automatic t_order();
        n_asg = 0;
        launch(6, 64, 0);
        check(busy == 1'b1, "R1 busy after launch", int'(busy), 1);
        launch(2, 64, 0);  // R11: ignored while busy
        wait_cyc(40);
        check(n_asg == 6, "R11 count kept", n_asg, 6);
        for (int i = 0; i < 6; i++) begin
            check(asg_ix[i] == i, "R1 index order", asg_ix[i], i);
            check(asg_sm[i] == i % NUM_SM, "R5 round-robin slot", asg_sm[i], i % NUM_SM);
        end
        drain("R9 done after drain");
        check(done_cyc == last_fin_cyc + 1, "R9 done timing", done_cyc, last_fin_cyc + 1);
        wait_cyc(3);
        check(done_seen == 1, "R9 single pulse", done_seen, 1);
        check(busy == 1'b0, "R9 idle after done", int'(busy), 0);
    endtask

    task automatic t_blk_cap();
        int per [NUM_SM];
        n_asg = 0;
        launch(40, 32, 0);
        wait_cyc(150);
        check(n_asg == 32, "R2 block cap total", n_asg, 32);
        for (int s = 0; s < NUM_SM; s++) per[s] = 0;
        for (int i = 0; i < 32; i++) per[asg_sm[i]]++;
        for (int s = 0; s < NUM_SM; s++) check(per[s] == 8, "R2 per slot", per[s], 8);
        complete(2);
        wait_cyc(10);
        check(n_asg == 33, "R7 refill count", n_asg, 33);
        check(asg_sm[32] == 2, "R7 refill slot", asg_sm[32], 2);
        check(asg_ix[32] == 32, "R7 refill index", asg_ix[32], 32);
        drain("R7 grid finishes");
        check(n_asg == 40, "R1 all issued", n_asg, 40);
    endtask

    task automatic t_thr_cap();
        n_asg = 0;
        launch(20, 256, 0);
        wait_cyc(80);
        check(n_asg == 12, "R3 thread cap", n_asg, 12);
        drain("R3 grid finishes");
        check(n_asg == 20, "R3 all issued", n_asg, 20);
    endtask

    task automatic t_smem_cap();
        n_asg = 0;
        launch(10, 32, 6000);
        wait_cyc(80);
        check(n_asg == 8, "R4 smem cap", n_asg, 8);
        drain("R4 grid finishes");
        n_asg = 0;
        launch(9, 32, 8192);
        wait_cyc(80);
        check(n_asg == 8, "R4 exact fill", n_asg, 8);
        drain("R4 exact grid finishes");
        check(n_asg == 9, "R4 all issued", n_asg, 9);
    endtask

    task automatic t_hold();
        int held;
        n_asg = 0;
        asg_ready = '0;
        launch(3, 32, 0);
        wait_cyc(10);
        check($countones(asg_valid) == 1, "R6 one offer", $countones(asg_valid), 1);
        held = 0;
        for (int s = 0; s < NUM_SM; s++) if (asg_valid[s]) held = s;
        check(asg_idx == '0, "R6 index zero", int'(asg_idx), 0);
        wait_cyc(10);
        check(asg_valid[held] == 1'b1 && $countones(asg_valid) == 1, "R6 offer held", int'(asg_valid), 1 << held);
        check(asg_idx == '0 && n_asg == 0, "R6 nothing taken", n_asg, 0);
        asg_ready = '1;
        wait_cyc(20);
        check(n_asg == 3 && asg_sm[0] == held, "R6 held slot wins", asg_sm[0], held);
        drain("R6 grid finishes");
    endtask

    task automatic t_reject();
        n_asg = 0;
        launch(5, 769, 0);
        check(launch_err == 1'b1, "R8 thread reject", int'(launch_err), 1);
        check(busy == 1'b0, "R8 stays idle", int'(busy), 0);
        wait_cyc(20);
        check(n_asg == 0 && asg_valid == '0, "R8 no issue", n_asg, 0);
        launch(5, 32, 16385);
        check(launch_err == 1'b1, "R8 smem reject", int'(launch_err), 1);
        launch(1, 768, 16384);
        check(launch_err == 1'b0 && busy == 1'b1, "R8 boundary accepted", int'(launch_err), 0);
        drain("R8 grid finishes");
        check(n_asg == 1, "R8 one issued", n_asg, 1);
    endtask

    task automatic t_proto();
        int seen0;
        seen0 = done_seen;
        check(proto_err == 1'b0, "R10 clean before", int'(proto_err), 0);
        complete(1);
        check(proto_err == 1'b1, "R10 stray completion", int'(proto_err), 1);
        check(busy == 1'b0 && asg_valid == '0, "R10 no effect", int'(busy), 0);
        wait_cyc(5);
        check(proto_err == 1'b1 && done_seen == seen0, "R10 sticky", int'(proto_err), 1);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_cyc(3);
        #1;
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_order();
        t_blk_cap();
        t_thr_cap();
        t_smem_cap();
        t_hold();
        t_reject();
        t_proto();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule